// File: doc/BRIEF.md
# Data Tag Propagation and Check Unit

This block computes the 4-bit tag that accompanies a 64-bit data word when an instruction writes a destination register or a memory word. It also reports a tag-check fault. One operation is presented per cycle. The operation is described by:

- an operation class (ALU, load, store or atomic read-modify-write);
- the tags of both source registers;
- a flag saying the second operand is an immediate;
- the tag currently held by the addressed memory word;
- a 64-bit tag control word.

The control word is split into 4-bit mask fields. Each class has its own masks, so software chooses at run time which tag bits flow to the result, which bits survive a store, and which bits trigger a fault.

The unit is pure combinational logic followed by an output register that can be selected by a parameter. The register is on by default. The block has two result ports:

- a register-tag result with its own write strobe;
- a memory-tag result with its own write strobe.

An atomic operation uses both result ports in the same cycle. The surrounding pipeline owns the register file, the cache and exception delivery. It simply consumes the result tags, the strobes, the fault flag and the 5-bit cause value.

Top module: `dtag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero on the following cycle, whatever the inputs.
- R2: Class code 1 (ALU) gives a register tag of (rs1 tag OR rs2 tag) AND the ALU propagate mask, taken from control bits [7:4]. It asserts `rd_tag_we_o` and keeps `mem_tag_we_o` low.
- R3: For an ALU operation with `rs2_imm_i` high, the rs2 tag is replaced by zero in both the result and the check. The flag has no effect on load or store classes.
- R4: An ALU operation raises `fault_o` when (rs1 tag OR effective rs2 tag) AND the ALU check mask, taken from control bits [3:0], is nonzero.
- R5: Class code 2 (load) gives a register tag of the memory tag AND the load propagate mask, taken from control bits [15:12]. All four bits are written, `rd_tag_we_o` is high and `mem_tag_we_o` is low.
- R6: A load raises `fault_o` when the memory tag AND the load check mask, taken from control bits [11:8], is nonzero.
- R7: Class code 3 (store) gives a new memory tag of (old memory tag AND keep mask, bits [27:24]) OR (rs2 tag AND store propagate mask, bits [23:20]). It asserts `mem_tag_we_o` and keeps `rd_tag_we_o` low.
- R8: A store raises `fault_o` when the old memory tag AND the store check mask, taken from control bits [19:16], is nonzero.
- R9: Class code 4 (atomic) produces the load register tag and the store memory tag together, with both strobes high. Its fault is the OR of the load check and the store check.
- R10: `cause_o` is 0x10 whenever `fault_o` is high, and 0 otherwise.
- R11: With an all-zero control word, both result tags are zero and no fault is raised, for every class and input.
- R12: Class code 0 and the unused codes 5 to 7 give zero tags, both strobes low and no fault. Control bits above bit 27 never affect any output.
- R13: With the output register enabled, outputs reflect the inputs present at the previous rising clock edge and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_cls_i | input | 3 | Operation class: 0 none, 1 ALU, 2 load, 3 store, 4 atomic |
| rs1_tag_i | input | 4 | Tag of the first source register |
| rs2_tag_i | input | 4 | Tag of the second source register |
| rs2_imm_i | input | 1 | Second ALU operand is an immediate |
| mem_tag_i | input | 4 | Tag currently stored with the addressed memory word |
| tag_ctrl_i | input | 64 | Tag control word holding the mask fields |
| rd_tag_o | output | 4 | New tag for the destination register |
| rd_tag_we_o | output | 1 | Destination register tag write strobe |
| mem_tag_o | output | 4 | New tag for the memory word |
| mem_tag_we_o | output | 1 | Memory tag write strobe |
| fault_o | output | 1 | Tag-check fault |
| cause_o | output | 5 | Fault cause value |

## Verification
Some properties are checked by assertions on every cycle:

- a fault always carries cause 0x10;
- an idle or unused class leaves every output quiet;
- an all-zero control word never yields a tag or a fault;
- a store never clears a memory tag bit that the keep mask protects;
- the strobes follow the class of the previous cycle.

The exact tag values for each class are shown only by the bench's directed scenarios. Those scenarios compare outputs against a model written from the equations. The same holds for:

- which mask field drives which result;
- the immediate override;
- the merged fault of an atomic operation;
- the one-cycle output timing.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_ALU   = 3'd1,
    CLS_LOAD  = 3'd2,
    CLS_STORE = 3'd3,
    CLS_AMO   = 3'd4
  } op_cls_e;

  // Mask field slots, in control-word order (slot k sits at bits k*TAG_W +: TAG_W)
  localparam int unsigned FLD_ALU_CHK  = 0;
  localparam int unsigned FLD_ALU_PROP = 1;
  localparam int unsigned FLD_LD_CHK   = 2;
  localparam int unsigned FLD_LD_PROP  = 3;
  localparam int unsigned FLD_ST_CHK   = 4;
  localparam int unsigned FLD_ST_PROP  = 5;
  localparam int unsigned FLD_ST_KEEP  = 6;
  localparam int unsigned NUM_FLDS     = 7;

  localparam int unsigned OP_W = 3;
endpackage

// File: rtl/dtag_mask_decode.sv
module dtag_mask_decode #(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned CTRL_W = 64,
  localparam int unsigned NFLD  = dtag_pkg::NUM_FLDS,
  localparam int unsigned USED_W = NFLD * TAG_W
) (
  input  logic [CTRL_W-1:0]          ctrl_i,
  output logic [NFLD-1:0][TAG_W-1:0] fld_o
);
  for (genvar k = 0; k < NFLD; k++) begin : g_fld
    assign fld_o[k] = ctrl_i[k*TAG_W +: TAG_W];
  end

  if (CTRL_W > USED_W) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^ctrl_i[CTRL_W-1:USED_W];
  end
endmodule

// File: rtl/dtag_alu_path.sv
module dtag_alu_path #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             en_i,
  input  logic [TAG_W-1:0] rs1_tag_i,
  input  logic [TAG_W-1:0] rs2_tag_i,
  input  logic             rs2_imm_i,
  input  logic [TAG_W-1:0] prop_i,
  input  logic [TAG_W-1:0] chk_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             fault_o
);
  logic [TAG_W-1:0] src2;
  logic [TAG_W-1:0] merged;

  always_comb begin
    src2    = rs2_imm_i ? '0 : rs2_tag_i;
    merged  = rs1_tag_i | src2;
    tag_o   = en_i ? (merged & prop_i) : '0;
    fault_o = en_i && ((merged & chk_i) != '0);
  end

  // A fault needs an enabled ALU op and a nonzero check mask
  always_comb begin
    p_alu_fault_mask_r4: assert (!fault_o || (en_i && chk_i != '0))
      else $error("ALU fault without check mask");
    // Result bits are always a subset of the propagate mask
    p_alu_tag_subset_r2: assert ((tag_o & ~prop_i) == '0)
      else $error("ALU tag outside propagate mask");
  end
endmodule

// File: rtl/dtag_mem_path.sv
module dtag_mem_path #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             ld_en_i,
  input  logic             st_en_i,
  input  logic [TAG_W-1:0] mem_tag_i,
  input  logic [TAG_W-1:0] rs2_tag_i,
  input  logic [TAG_W-1:0] ld_prop_i,
  input  logic [TAG_W-1:0] ld_chk_i,
  input  logic [TAG_W-1:0] st_prop_i,
  input  logic [TAG_W-1:0] st_keep_i,
  input  logic [TAG_W-1:0] st_chk_i,
  output logic [TAG_W-1:0] ld_tag_o,
  output logic [TAG_W-1:0] st_tag_o,
  output logic             ld_fault_o,
  output logic             st_fault_o
);
  always_comb begin
    ld_tag_o   = ld_en_i ? (mem_tag_i & ld_prop_i) : '0;
    ld_fault_o = ld_en_i && ((mem_tag_i & ld_chk_i) != '0);
    st_tag_o   = st_en_i ? ((mem_tag_i & st_keep_i) | (rs2_tag_i & st_prop_i)) : '0;
    st_fault_o = st_en_i && ((mem_tag_i & st_chk_i) != '0);
  end

  always_comb begin
    // Protected bits of the old memory tag survive a store
    p_keep_bits_r7: assert (!st_en_i || ((mem_tag_i & st_keep_i & ~st_tag_o) == '0))
      else $error("store cleared a kept tag bit");
    // Load result never exceeds the memory tag
    p_load_subset_r5: assert ((ld_tag_o & ~mem_tag_i) == '0)
      else $error("load tag has bits not in memory tag");
  end
endmodule

// File: rtl/dtag_out_stage.sv
module dtag_out_stage #(
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_CODE = 5'h10,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   rd_tag_d,
  input  logic               rd_we_d,
  input  logic [TAG_W-1:0]   mem_tag_d,
  input  logic               mem_we_d,
  input  logic               fault_d,
  output logic [TAG_W-1:0]   rd_tag_q,
  output logic               rd_we_q,
  output logic [TAG_W-1:0]   mem_tag_q,
  output logic               mem_we_q,
  output logic               fault_q,
  output logic [CAUSE_W-1:0] cause_q
);
  logic [CAUSE_W-1:0] cause_d;
  assign cause_d = fault_d ? CAUSE_CODE : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_tag_q  <= '0;
        rd_we_q   <= 1'b0;
        mem_tag_q <= '0;
        mem_we_q  <= 1'b0;
        fault_q   <= 1'b0;
        cause_q   <= '0;
      end else begin
        rd_tag_q  <= rd_tag_d;
        rd_we_q   <= rd_we_d;
        mem_tag_q <= mem_tag_d;
        mem_we_q  <= mem_we_d;
        fault_q   <= fault_d;
        cause_q   <= cause_d;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign rd_tag_q  = rd_tag_d;
    assign rd_we_q   = rd_we_d;
    assign mem_tag_q = mem_tag_d;
    assign mem_we_q  = mem_we_d;
    assign fault_q   = fault_d;
    assign cause_q   = cause_d;
  end
endmodule

// File: rtl/dtag_unit.sv
module dtag_unit #(
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned CTRL_W  = 64,
  parameter int unsigned CAUSE_W = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [dtag_pkg::OP_W-1:0] op_cls_i,
  input  logic [TAG_W-1:0]          rs1_tag_i,
  input  logic [TAG_W-1:0]          rs2_tag_i,
  input  logic                      rs2_imm_i,
  input  logic [TAG_W-1:0]          mem_tag_i,
  input  logic [CTRL_W-1:0]         tag_ctrl_i,
  output logic [TAG_W-1:0]          rd_tag_o,
  output logic                      rd_tag_we_o,
  output logic [TAG_W-1:0]          mem_tag_o,
  output logic                      mem_tag_we_o,
  output logic                      fault_o,
  output logic [CAUSE_W-1:0]        cause_o
);
  import dtag_pkg::*;

  localparam logic [CAUSE_W-1:0] TAG_FAULT_CAUSE = CAUSE_W'(5'h10);

  logic [NUM_FLDS-1:0][TAG_W-1:0] fld;
  logic is_alu, do_load, do_store;
  logic [TAG_W-1:0] alu_tag, ld_tag, st_tag;
  logic alu_fault, ld_fault, st_fault;

  always_comb begin
    is_alu   = (op_cls_i == CLS_ALU);
    do_load  = (op_cls_i == CLS_LOAD)  || (op_cls_i == CLS_AMO);
    do_store = (op_cls_i == CLS_STORE) || (op_cls_i == CLS_AMO);
  end

  dtag_mask_decode #(.TAG_W(TAG_W), .CTRL_W(CTRL_W)) u_dec (
    .ctrl_i (tag_ctrl_i),
    .fld_o  (fld)
  );

  dtag_alu_path #(.TAG_W(TAG_W)) u_alu (
    .en_i      (is_alu),
    .rs1_tag_i (rs1_tag_i),
    .rs2_tag_i (rs2_tag_i),
    .rs2_imm_i (rs2_imm_i),
    .prop_i    (fld[FLD_ALU_PROP]),
    .chk_i     (fld[FLD_ALU_CHK]),
    .tag_o     (alu_tag),
    .fault_o   (alu_fault)
  );

  dtag_mem_path #(.TAG_W(TAG_W)) u_mem (
    .ld_en_i    (do_load),
    .st_en_i    (do_store),
    .mem_tag_i  (mem_tag_i),
    .rs2_tag_i  (rs2_tag_i),
    .ld_prop_i  (fld[FLD_LD_PROP]),
    .ld_chk_i   (fld[FLD_LD_CHK]),
    .st_prop_i  (fld[FLD_ST_PROP]),
    .st_keep_i  (fld[FLD_ST_KEEP]),
    .st_chk_i   (fld[FLD_ST_CHK]),
    .ld_tag_o   (ld_tag),
    .st_tag_o   (st_tag),
    .ld_fault_o (ld_fault),
    .st_fault_o (st_fault)
  );

  dtag_out_stage #(
    .TAG_W(TAG_W), .CAUSE_W(CAUSE_W), .CAUSE_CODE(TAG_FAULT_CAUSE), .REG_OUT(REG_OUT)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_tag_d  (alu_tag | ld_tag),
    .rd_we_d   (is_alu | do_load),
    .mem_tag_d (st_tag),
    .mem_we_d  (do_store),
    .fault_d   (alu_fault | ld_fault | st_fault),
    .rd_tag_q  (rd_tag_o),
    .rd_we_q   (rd_tag_we_o),
    .mem_tag_q (mem_tag_o),
    .mem_we_q  (mem_tag_we_o),
    .fault_q   (fault_o),
    .cause_q   (cause_o)
  );

  // Cause value tracks the fault flag (R10)
  p_cause_match_r10: assert property (@(posedge clk) disable iff (rst)
    fault_o ? (cause_o == TAG_FAULT_CAUSE) : (cause_o == '0));

  if (REG_OUT) begin : g_chk
    logic primed;
    always_ff @(posedge clk) begin
      if (rst) primed <= 1'b0;
      else     primed <= 1'b1;
    end

    // Idle and unused classes leave the outputs quiet (R12)
    p_none_quiet_r12: assert property (@(posedge clk) disable iff (rst || !primed)
      ($past(op_cls_i) == CLS_NONE || $past(op_cls_i) > CLS_AMO) |->
        (!rd_tag_we_o && !mem_tag_we_o && !fault_o && rd_tag_o == '0 && mem_tag_o == '0));

    // All-zero control word yields no tag and no fault (R11)
    p_zero_ctrl_r11: assert property (@(posedge clk) disable iff (rst || !primed)
      ($past(tag_ctrl_i) == '0) |-> (!fault_o && rd_tag_o == '0 && mem_tag_o == '0));

    // Strobes follow the class seen one edge earlier (R13)
    p_strobe_latency_r13: assert property (@(posedge clk) disable iff (rst || !primed)
      (mem_tag_we_o == ($past(op_cls_i) == CLS_STORE || $past(op_cls_i) == CLS_AMO)));

    // Atomic op writes both targets (R9)
    p_amo_both_r9: assert property (@(posedge clk) disable iff (rst)
      (op_cls_i == CLS_AMO) |=> (rd_tag_we_o && mem_tag_we_o));

    // Reset clears outputs (R1)
    p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) && primed == 1'b0 && !rst |-> (!fault_o && !rd_tag_we_o && !mem_tag_we_o));
  end
endmodule

// File: tb/sim_dtag_unit.sv
module sim_dtag_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op_cls;
  logic [3:0]  rs1_tag, rs2_tag, mem_tag;
  logic        rs2_imm;
  logic [63:0] tag_ctrl;
  logic [3:0]  rd_tag_o, mem_tag_o;
  logic        rd_we_o, mem_we_o, fault_o;
  logic [4:0]  cause_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dtag_unit u0 (
    .clk(clk), .rst(rst), .op_cls_i(op_cls), .rs1_tag_i(rs1_tag), .rs2_tag_i(rs2_tag),
    .rs2_imm_i(rs2_imm), .mem_tag_i(mem_tag), .tag_ctrl_i(tag_ctrl),
    .rd_tag_o(rd_tag_o), .rd_tag_we_o(rd_we_o), .mem_tag_o(mem_tag_o),
    .mem_tag_we_o(mem_we_o), .fault_o(fault_o), .cause_o(cause_o)
  );

  // Field order: achk, aprop, lchk, lprop, schk, sprop, keep; junk in bits above 27
  function automatic logic [63:0] mk_ctrl(input logic [3:0] achk, aprop, lchk, lprop,
                                          schk, sprop, keep, input logic [35:0] junk);
    return {junk, keep, sprop, schk, lprop, lchk, aprop, achk};
  endfunction

  // Packed expected view: {rd_tag, rd_we, mem_tag, mem_we, fault, cause}
  function automatic logic [15:0] model(input logic [2:0] op, input logic [3:0] r1, r2,
                                        input logic imm, input logic [3:0] mt,
                                        input logic [63:0] c);
    logic [3:0] rd = 4'h0, mw = 4'h0, src;
    logic rwe = 0, mwe = 0, f = 0;
    case (op)
      3'd1: begin
        src = r1 | (imm ? 4'h0 : r2);
        rd = src & c[7:4]; rwe = 1; f = (src & c[3:0]) != 0;
      end
      3'd2: begin rd = mt & c[15:12]; rwe = 1; f = (mt & c[11:8]) != 0; end
      3'd3: begin mw = (mt & c[27:24]) | (r2 & c[23:20]); mwe = 1; f = (mt & c[19:16]) != 0; end
      3'd4: begin
        rd = mt & c[15:12]; rwe = 1; mw = (mt & c[27:24]) | (r2 & c[23:20]); mwe = 1;
        f = ((mt & c[11:8]) != 0) || ((mt & c[19:16]) != 0);
      end
      default: ;
    endcase
    return {rd, rwe, mw, mwe, f, (f ? 5'h10 : 5'h00)};
  endfunction

  function automatic logic [15:0] outs();
    return {rd_tag_o, rd_we_o, mem_tag_o, mem_we_o, fault_o, cause_o};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [3:0] r1, r2, input logic imm,
                       input logic [3:0] mt, input logic [63:0] c);
    @(negedge clk);
    op_cls = op; rs1_tag = r1; rs2_tag = r2; rs2_imm = imm; mem_tag = mt; tag_ctrl = c;
  endtask

  // Drive, let one edge pass, compare against the model
  task automatic run(input string req, input logic [2:0] op, input logic [3:0] r1, r2,
                     input logic imm, input logic [3:0] mt, input logic [63:0] c);
    drive(op, r1, r2, imm, mt, c);
    @(negedge clk);
    check(req, outs(), model(op, r1, r2, imm, mt, c));
  endtask

  task automatic t_reset_r1();
    rst = 1'b1;
    drive(3'd4, 4'hF, 4'hF, 1'b0, 4'hF, '1);
    @(negedge clk);
    check("R1 reset", outs(), 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_alu_r2();
    logic [63:0] c = mk_ctrl(4'h0, 4'hA, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 36'h0);
    run("R2 alu or/and", 3'd1, 4'h3, 4'h8, 1'b0, 4'hF, c);
    run("R2 alu second", 3'd1, 4'h1, 4'h4, 1'b0, 4'h0, mk_ctrl(0, 4'hF, 0, 0, 0, 0, 0, 36'h0));
  endtask

  task automatic t_imm_r3();
    logic [63:0] c = mk_ctrl(4'h8, 4'hF, 4'hF, 4'hF, 4'h0, 4'hF, 4'h0, 36'h0);
    run("R3 imm zeroes rs2", 3'd1, 4'h1, 4'h8, 1'b1, 4'h0, c);
    run("R3 imm ignored on store", 3'd3, 4'h0, 4'h6, 1'b1, 4'h0, c);
  endtask

  task automatic t_alu_chk_r4();
    logic [63:0] c = mk_ctrl(4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 36'h0);
    run("R4 alu fault rs2", 3'd1, 4'h0, 4'h4, 1'b0, 4'h0, c);
    run("R4 alu no fault", 3'd1, 4'h3, 4'h8, 1'b0, 4'h4, c);
  endtask

  task automatic t_load_r5_r6();
    logic [63:0] c = mk_ctrl(4'hF, 4'hF, 4'h2, 4'h9, 4'hF, 4'hF, 4'hF, 36'h0);
    run("R5 load prop", 3'd2, 4'hF, 4'hF, 1'b0, 4'hD, c);
    run("R6 load fault", 3'd2, 4'h0, 4'h0, 1'b0, 4'h2, c);
    run("R6 load clean", 3'd2, 4'h0, 4'h0, 1'b0, 4'h1, c);
  endtask

  task automatic t_store_r7_r8();
    logic [63:0] c = mk_ctrl(4'hF, 4'hF, 4'hF, 4'hF, 4'h1, 4'h6, 4'h9, 36'h0);
    run("R7 store keep/prop", 3'd3, 4'hF, 4'hE, 1'b0, 4'hA, c);
    run("R8 store fault", 3'd3, 4'h0, 4'h0, 1'b0, 4'h1, c);
    run("R8 store clean", 3'd3, 4'h0, 4'h0, 1'b0, 4'h6, c);
  endtask

  task automatic t_amo_r9_r10();
    logic [63:0] c = mk_ctrl(4'h0, 4'h0, 4'h1, 4'hC, 4'h8, 4'h3, 4'h4, 36'h0);
    run("R9 amo load fault", 3'd4, 4'h0, 4'h3, 1'b0, 4'h5, c);
    run("R9 amo store fault", 3'd4, 4'h0, 4'h1, 1'b0, 4'hC, c);
    run("R10 amo clean cause", 3'd4, 4'h0, 4'h2, 1'b0, 4'h6, c);
  endtask

  task automatic t_zero_ctrl_r11();
    for (int op = 1; op <= 4; op++)
      run("R11 zero ctrl", 3'(op), 4'hF, 4'hF, 1'b0, 4'hF, 64'h0);
  endtask

  task automatic t_none_r12();
    logic [63:0] c = mk_ctrl(4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 36'hF_FFFF_FFFF);
    run("R12 class none", 3'd0, 4'hF, 4'hF, 1'b0, 4'hF, c);
    run("R12 class 5", 3'd5, 4'hF, 4'hF, 1'b0, 4'hF, c);
    run("R12 class 7", 3'd7, 4'hF, 4'hF, 1'b0, 4'hF, c);
    run("R12 upper bits ignored", 3'd1, 4'h0, 4'h0, 1'b0, 4'h0,
        mk_ctrl(0, 0, 0, 0, 0, 0, 0, 36'hF_FFFF_FFFF));
  endtask

  task automatic t_latency_r13();
    logic [63:0] c = mk_ctrl(4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 36'h0);
    logic [15:0] prev;
    run("R13 setup", 3'd1, 4'h1, 4'h0, 1'b0, 4'h0, c);
    prev = outs();
    drive(3'd1, 4'h6, 4'h0, 1'b0, 4'h0, c);
    #5;
    check("R13 hold before edge", outs(), prev);
    @(negedge clk);
    check("R13 update after edge", outs(), model(3'd1, 4'h6, 4'h0, 1'b0, 4'h0, c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_cls = '0; rs1_tag = '0; rs2_tag = '0; rs2_imm = 1'b0;
    mem_tag = '0; tag_ctrl = '0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_alu_r2();
    t_imm_r3();
    t_alu_chk_r4();
    t_load_r5_r6();
    t_store_r7_r8();
    t_amo_r9_r10();
    t_zero_ctrl_r11();
    t_none_r12();
    t_latency_r13();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule